// File: doc/BRIEF.md
# Hardware Lock Manager with Queued Waiters

This block is a central lock server that several cores share. A core sends an acquire or a release for a lock number. The manager keeps, for each lock, whether it is taken, which core owns it, and a first-come queue of the cores that are waiting for it. Acquire and release are pure synchronization commands and touch no data memory. A core enters its critical section only after the manager sends it a grant. A core that finds the lock taken is parked in the queue and does not poll. When the owner lets go, the manager passes the lock to the oldest waiter and grants it.

Each core has its own request channel (valid/ready, an operation bit and a lock number) and its own grant strobe, which carries the number of the granted lock. In each cycle the manager accepts at most one release and one acquire. When both name the same lock, the release is applied first. A release from a core that does not own the lock is refused, and an error strobe names the offending core. The manager also follows the wait-for chain in hardware (waiting core, then the lock it waits on, then that lock's owner) and raises a deadlock flag that names a core on the cycle.

Top module: `lock_mgr`

## Requirements
- R1: An accepted acquire of a free lock makes the lock owned by the requester, and in the next cycle `grant_valid_o[c]` of that core is high for one cycle with the lock number in field `c` of `grant_lock_o` (bits `c*LOCK_W +: LOCK_W`).
- R2: An accepted acquire of a lock that is taken produces no grant and places the core in that lock's wait queue. While the core waits, its acquire requests are not accepted (`req_ready_o[c]` stays low).
- R3: A release by the owner of a lock that has waiters hands the lock to the waiter that arrived first. That waiter is granted in the next cycle, and waiters are served in arrival order.
- R4: A release by the owner of a lock with no waiters frees the lock, and a later acquire of that lock is granted.
- R5: A release by a core that does not own the lock, or of a free lock, changes nothing. In the next cycle `rel_err_o` pulses with `rel_err_core_o` set to the releasing core.
- R6: When a release and an acquire of the same lock are accepted in the same cycle, the release takes effect first. The acquirer is granted at once if the queue was empty, and is otherwise queued behind the existing waiters.
- R7: If the waiting cores form a closed wait-for chain (this includes a core that acquires a lock it already owns), `deadlock_o` is high from the second cycle after the acquire that closed the chain, and `deadlock_core_o` names a core on the chain. `deadlock_o` stays low while every chain ends at a running owner.
- R8: During reset and after it, no grant, error or deadlock output is active and all locks are free.
- R9: In each cycle at most one release and at most one acquire are accepted. Releases go to the lowest-index core, and acquires rotate among cores starting after the last one served; after reset, core 0 has the first turn.
- Encoding: `req_rel_i[c]` set to 1 means release and 0 means acquire. The lock number for core `c` is at bits `c*LOCK_W +: LOCK_W` of `req_lock_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | N_CORES | Request valid per core |
| req_rel_i | input | N_CORES | Operation per core: 1 release, 0 acquire |
| req_lock_i | input | N_CORES*LOCK_W | Lock number per core |
| req_ready_o | output | N_CORES | Request accepted this cycle per core |
| grant_valid_o | output | N_CORES | One-cycle grant strobe per core |
| grant_lock_o | output | N_CORES*LOCK_W | Granted lock number per core |
| rel_err_o | output | 1 | Refused release strobe |
| rel_err_core_o | output | CORE_W | Core whose release was refused |
| deadlock_o | output | 1 | Wait-for cycle present |
| deadlock_core_o | output | CORE_W | A core on the wait-for cycle |

## Verification
The case where two operations coincide is a release and an acquire of the same lock accepted in one edge. The bench provokes it by forking two request tasks that start at the same falling edge. It first does this with an empty queue, where the acquirer must be granted on the edge that frees the lock. It then repeats it with a waiter already queued, where the oldest waiter must get the grant and the acquirer must be queued and only served at the next release. The scoreboard judges both cases from the order of grant strobes: an early, extra or misordered grant fails a check.

// File: rtl/lock_mgr_pkg.sv
package lock_mgr_pkg;
  typedef enum logic {
    OP_ACQ = 1'b0,
    OP_REL = 1'b1
  } lock_op_e;

  function automatic int wrap_inc(int v, int n);
    return (v + 1 >= n) ? 0 : v + 1;
  endfunction
endpackage

// File: rtl/lm_rr_arb.sv
module lm_rr_arb #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  localparam int W = (N > 1) ? $clog2(N) : 1;

  logic [W-1:0] ptr_q;
  logic [W-1:0] nxt_ptr;
  logic         found;

  always_comb begin
    gnt_o   = '0;
    found   = 1'b0;
    nxt_ptr = ptr_q;
    for (int i = 0; i < N; i++) begin
      int idx;
      idx = (int'(ptr_q) + i) % N;
      if (!found && req_i[idx]) begin
        found      = 1'b1;
        gnt_o[idx] = 1'b1;
        nxt_ptr    = W'(lock_mgr_pkg::wrap_inc(idx, N));
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else if (found) ptr_q <= nxt_ptr;
  end
endmodule

// File: rtl/lm_wait_queue.sv
module lm_wait_queue #(
  parameter int N_CORES = 8,
  parameter int CORE_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [CORE_W-1:0] push_id_i,
  input  logic              pop_i,
  output logic [CORE_W-1:0] head_o,
  output logic              empty_o
);
  localparam int CNT_W = $clog2(N_CORES + 1);

  logic [CORE_W-1:0] slot_q [N_CORES];
  logic [CORE_W-1:0] head_q;
  logic [CNT_W-1:0]  cnt_q;
  int                tail;

  assign head_o  = slot_q[head_q];
  assign empty_o = (cnt_q == '0);

  always_comb begin
    tail = int'(head_q) + int'(cnt_q);
    if (tail >= N_CORES) tail = tail - N_CORES;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      cnt_q  <= '0;
      for (int i = 0; i < N_CORES; i++) slot_q[i] <= '0;
    end else begin
      if (push_i) slot_q[tail] <= push_id_i;
      if (pop_i) head_q <= CORE_W'(lock_mgr_pkg::wrap_inc(int'(head_q), N_CORES));
      cnt_q <= cnt_q + CNT_W'(push_i) - CNT_W'(pop_i);
    end
  end
endmodule

// File: rtl/lm_deadlock_det.sv
module lm_deadlock_det #(
  parameter int N_CORES = 8,
  parameter int N_LOCKS = 4,
  parameter int CORE_W  = 3,
  parameter int LOCK_W  = 2
) (
  input  logic [N_CORES-1:0] waiting_i,
  input  logic [LOCK_W-1:0]  wait_lock_i [N_CORES],
  input  logic [CORE_W-1:0]  owner_i     [N_LOCKS],
  output logic               found_o,
  output logic [CORE_W-1:0]  core_o
);
  // N hops that all land on a waiting core can only be a loop.
  always_comb begin
    found_o = 1'b0;
    core_o  = '0;
    for (int s = 0; s < N_CORES; s++) begin
      logic [CORE_W-1:0] cur;
      logic              live;
      cur  = CORE_W'(s);
      live = 1'b1;
      for (int k = 0; k < N_CORES; k++) begin
        if (live && waiting_i[cur]) cur = owner_i[wait_lock_i[cur]];
        else live = 1'b0;
      end
      if (live && !found_o) begin
        found_o = 1'b1;
        core_o  = cur;
      end
    end
  end
endmodule

// File: rtl/lock_mgr.sv
module lock_mgr #(
  parameter int N_CORES = 8,
  parameter int N_LOCKS = 4,
  localparam int CORE_W = (N_CORES > 1) ? $clog2(N_CORES) : 1,
  localparam int LOCK_W = (N_LOCKS > 1) ? $clog2(N_LOCKS) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [N_CORES-1:0]         req_valid_i,
  input  logic [N_CORES-1:0]         req_rel_i,
  input  logic [N_CORES*LOCK_W-1:0]  req_lock_i,
  output logic [N_CORES-1:0]         req_ready_o,
  output logic [N_CORES-1:0]         grant_valid_o,
  output logic [N_CORES*LOCK_W-1:0]  grant_lock_o,
  output logic                       rel_err_o,
  output logic [CORE_W-1:0]          rel_err_core_o,
  output logic                       deadlock_o,
  output logic [CORE_W-1:0]          deadlock_core_o
);
  import lock_mgr_pkg::*;

  logic [N_LOCKS-1:0] locked_q;
  logic [CORE_W-1:0]  owner_q     [N_LOCKS];
  logic [N_CORES-1:0] waiting_q;
  logic [LOCK_W-1:0]  wait_lock_q [N_CORES];

  logic [N_CORES-1:0] rel_cand, acq_cand, rel_sel, acq_sel;
  logic               rel_fire, acq_fire, rel_ok;
  logic [CORE_W-1:0]  rel_core, acq_core;
  logic [LOCK_W-1:0]  rel_lock, acq_lock;

  logic [CORE_W-1:0]  q_head  [N_LOCKS];
  logic [N_LOCKS-1:0] q_empty, q_push, q_pop;

  logic [N_CORES-1:0] grant_d;
  logic [LOCK_W-1:0]  grant_lock_d [N_CORES];
  logic [LOCK_W-1:0]  grant_lock_q [N_CORES];
  logic [N_LOCKS-1:0] locked_d;
  logic [CORE_W-1:0]  owner_d      [N_LOCKS];
  logic [N_CORES-1:0] waiting_d;
  logic [LOCK_W-1:0]  wait_lock_d  [N_CORES];

  logic               dl_found;
  logic [CORE_W-1:0]  dl_core;

  // Request selection
  always_comb begin
    for (int c = 0; c < N_CORES; c++) begin
      rel_cand[c] = req_valid_i[c] && (lock_op_e'(req_rel_i[c]) == OP_REL);
      acq_cand[c] = req_valid_i[c] && (lock_op_e'(req_rel_i[c]) == OP_ACQ) && !waiting_q[c];
    end
  end

  always_comb begin
    rel_sel = '0;
    for (int c = N_CORES - 1; c >= 0; c--) begin
      if (rel_cand[c]) rel_sel = N_CORES'(1) << c;
    end
  end

  lm_rr_arb #(.N(N_CORES)) u_acq_arb (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (acq_cand),
    .gnt_o (acq_sel)
  );

  assign req_ready_o = rel_sel | acq_sel;
  assign rel_fire    = |rel_sel;
  assign acq_fire    = |acq_sel;

  always_comb begin
    rel_core = '0;
    acq_core = '0;
    rel_lock = '0;
    acq_lock = '0;
    for (int c = 0; c < N_CORES; c++) begin
      if (rel_sel[c]) begin
        rel_core = CORE_W'(c);
        rel_lock = req_lock_i[c*LOCK_W +: LOCK_W];
      end
      if (acq_sel[c]) begin
        acq_core = CORE_W'(c);
        acq_lock = req_lock_i[c*LOCK_W +: LOCK_W];
      end
    end
  end

  assign rel_ok = rel_fire && locked_q[rel_lock] && (owner_q[rel_lock] == rel_core);

  // Per-lock waiter queues
  for (genvar l = 0; l < N_LOCKS; l++) begin : g_lock
    lm_wait_queue #(.N_CORES(N_CORES), .CORE_W(CORE_W)) u_q (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .push_i   (q_push[l]),
      .push_id_i(acq_core),
      .pop_i    (q_pop[l]),
      .head_o   (q_head[l]),
      .empty_o  (q_empty[l])
    );
  end

  // Next state: release applied before acquire
  always_comb begin
    locked_d    = locked_q;
    owner_d     = owner_q;
    waiting_d   = waiting_q;
    wait_lock_d = wait_lock_q;
    grant_d     = '0;
    for (int c = 0; c < N_CORES; c++) grant_lock_d[c] = '0;
    q_push = '0;
    q_pop  = '0;
    for (int l = 0; l < N_LOCKS; l++) begin
      logic rel_hit, acq_hit, free_after;
      rel_hit    = rel_ok && (rel_lock == LOCK_W'(l));
      acq_hit    = acq_fire && (acq_lock == LOCK_W'(l));
      free_after = !locked_q[l] || (rel_hit && q_empty[l]);
      if (rel_hit) begin
        if (q_empty[l]) begin
          locked_d[l] = 1'b0;
        end else begin
          q_pop[l]                  = 1'b1;
          owner_d[l]                = q_head[l];
          waiting_d[q_head[l]]      = 1'b0;
          grant_d[q_head[l]]        = 1'b1;
          grant_lock_d[q_head[l]]   = LOCK_W'(l);
        end
      end
      if (acq_hit) begin
        if (free_after) begin
          locked_d[l]            = 1'b1;
          owner_d[l]             = acq_core;
          grant_d[acq_core]      = 1'b1;
          grant_lock_d[acq_core] = LOCK_W'(l);
        end else begin
          q_push[l]             = 1'b1;
          waiting_d[acq_core]   = 1'b1;
          wait_lock_d[acq_core] = LOCK_W'(l);
        end
      end
    end
  end

  lm_deadlock_det #(
    .N_CORES(N_CORES), .N_LOCKS(N_LOCKS), .CORE_W(CORE_W), .LOCK_W(LOCK_W)
  ) u_dl (
    .waiting_i  (waiting_q),
    .wait_lock_i(wait_lock_q),
    .owner_i    (owner_q),
    .found_o    (dl_found),
    .core_o     (dl_core)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_q        <= '0;
      waiting_q       <= '0;
      grant_valid_o   <= '0;
      rel_err_o       <= 1'b0;
      rel_err_core_o  <= '0;
      deadlock_o      <= 1'b0;
      deadlock_core_o <= '0;
      for (int l = 0; l < N_LOCKS; l++) owner_q[l] <= '0;
      for (int c = 0; c < N_CORES; c++) begin
        wait_lock_q[c]  <= '0;
        grant_lock_q[c] <= '0;
      end
    end else begin
      locked_q        <= locked_d;
      owner_q         <= owner_d;
      waiting_q       <= waiting_d;
      wait_lock_q     <= wait_lock_d;
      grant_valid_o   <= grant_d;
      grant_lock_q    <= grant_lock_d;
      rel_err_o       <= rel_fire && !rel_ok;
      rel_err_core_o  <= rel_core;
      deadlock_o      <= dl_found;
      deadlock_core_o <= dl_core;
    end
  end

  for (genvar c = 0; c < N_CORES; c++) begin : g_out
    assign grant_lock_o[c*LOCK_W +: LOCK_W] = grant_lock_q[c];
  end
endmodule

// File: rtl/lock_mgr_chk.sv
module lock_mgr_chk #(
  parameter int N_CORES = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [N_CORES-1:0] req_valid_i,
  input logic [N_CORES-1:0] req_rel_i,
  input logic [N_CORES-1:0] req_ready_o,
  input logic [N_CORES-1:0] grant_valid_o,
  input logic               rel_err_o,
  input logic               deadlock_o,
  input logic [N_CORES-1:0] waiting_i
);
  logic [N_CORES-1:0] acc;
  assign acc = req_valid_i & req_ready_o;

  a_r1_grant_follows_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_valid_o != '0) |-> $past(acc != '0));

  a_r5_err_follows_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_err_o |-> $past((acc & req_rel_i) != '0));

  a_r9_one_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(acc & req_rel_i) <= 1);

  a_r9_one_acquire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(acc & ~req_rel_i) <= 1);

  a_r7_deadlock_needs_waiters: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deadlock_o |-> $past(waiting_i != '0));

  for (genvar c = 0; c < N_CORES; c++) begin : g_core
    a_r2_waiter_held_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (waiting_i[c] && req_valid_i[c] && !req_rel_i[c]) |-> !req_ready_o[c]);
  end
endmodule

bind lock_mgr lock_mgr_chk #(.N_CORES(N_CORES)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_rel_i    (req_rel_i),
  .req_ready_o  (req_ready_o),
  .grant_valid_o(grant_valid_o),
  .rel_err_o    (rel_err_o),
  .deadlock_o   (deadlock_o),
  .waiting_i    (waiting_q)
);

// File: tb/sim_lock_mgr.sv
`timescale 1ns/1ps
module sim_lock_mgr;
  localparam int NC = 8;
  localparam int NL = 4;
  localparam int CW = 3;
  localparam int LW = 2;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic [NC-1:0]    req_valid = '0;
  logic [NC-1:0]    req_rel = '0;
  logic [NC*LW-1:0] req_lock = '0;
  logic [NC-1:0]    req_ready_o;
  logic [NC-1:0]    grant_valid_o;
  logic [NC*LW-1:0] grant_lock_o;
  logic             rel_err_o;
  logic [CW-1:0]    rel_err_core_o;
  logic             deadlock_o;
  logic [CW-1:0]    deadlock_core_o;

  always #2 clk = ~clk;

  lock_mgr #(.N_CORES(NC), .N_LOCKS(NL)) u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid), .req_rel_i(req_rel), .req_lock_i(req_lock),
    .req_ready_o(req_ready_o), .grant_valid_o(grant_valid_o), .grant_lock_o(grant_lock_o),
    .rel_err_o(rel_err_o), .rel_err_core_o(rel_err_core_o),
    .deadlock_o(deadlock_o), .deadlock_core_o(deadlock_core_o)
  );

  typedef struct { int core; int lock; string req; } exp_t;
  exp_t exp_q[$];
  int   total = 0;
  int   bad = 0;
  bit   done = 1'b0;

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic expect_grant(int c, int l, string req);
    exp_t e;
    e.core = c; e.lock = l; e.req = req;
    exp_q.push_back(e);
  endtask

  // called at a falling edge; returns at the falling edge after acceptance
  task automatic send(int c, bit rel, int l);
    req_valid[c] = 1'b1;
    req_rel[c]   = rel;
    req_lock[c*LW +: LW] = LW'(l);
    #1;
    while (!req_ready_o[c]) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    @(negedge clk);
    req_valid[c] = 1'b0;
  endtask

  task automatic do_reset();
    chk(exp_q.size() == 0, "R3 pending grants before reset", exp_q.size(), 0);
    exp_q.delete();
    req_valid = '0;
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    chk(grant_valid_o == '0 && !rel_err_o && !deadlock_o, "R8 reset outputs",
        int'(grant_valid_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_ni) begin
        for (int c = 0; c < NC; c++) begin
          if (grant_valid_o[c]) begin
            int gl;
            gl = int'(grant_lock_o[c*LW +: LW]);
            if (exp_q.size() == 0) begin
              chk(1'b0, "R1/R2 unexpected grant core", c, -1);
            end else begin
              exp_t e;
              e = exp_q.pop_front();
              chk(e.core == c && e.lock == gl, e.req, c*16 + gl, e.core*16 + e.lock);
            end
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();

    // R1 free lock
    expect_grant(2, 1, "R1 grant free lock");
    send(2, 1'b0, 1);
    // R2 queue behind owner
    send(4, 1'b0, 1);
    send(5, 1'b0, 1);
    req_valid[4] = 1'b1; req_rel[4] = 1'b0; req_lock[4*LW +: LW] = 2'd2;
    #1;
    chk(!req_ready_o[4], "R2 waiter acquire held off", int'(req_ready_o[4]), 0);
    @(negedge clk);
    req_valid[4] = 1'b0;
    chk(!deadlock_o, "R7 no false deadlock", int'(deadlock_o), 0);
    // R3 FIFO handoff
    expect_grant(4, 1, "R3 first waiter");
    send(2, 1'b1, 1);
    expect_grant(5, 1, "R3 second waiter");
    send(4, 1'b1, 1);
    // R4 free then reacquire
    send(5, 1'b1, 1);
    chk(!rel_err_o, "R4 owner release no error", int'(rel_err_o), 0);
    expect_grant(0, 1, "R4 reacquire after free");
    send(0, 1'b0, 1);
    send(0, 1'b1, 1);

    // R5 foreign release refused
    expect_grant(2, 0, "R1 grant lock 0");
    send(2, 1'b0, 0);
    send(6, 1'b1, 0);
    chk(rel_err_o && rel_err_core_o == 3'd6, "R5 foreign release error",
        int'(rel_err_core_o), 6);
    send(7, 1'b0, 0);
    @(negedge clk);
    expect_grant(7, 0, "R5 owner kept after refused release");
    send(2, 1'b1, 0);
    send(7, 1'b1, 0);
    send(5, 1'b1, 3);
    chk(rel_err_o && rel_err_core_o == 3'd5, "R5 release of free lock", int'(rel_err_o), 1);

    // R6 same-cycle release and acquire, empty queue
    expect_grant(1, 2, "R1 grant lock 2");
    send(1, 1'b0, 2);
    expect_grant(3, 2, "R6 release first, acquirer granted");
    fork
      send(1, 1'b1, 2);
      send(3, 1'b0, 2);
    join
    // R6 with a waiter queued
    send(0, 1'b0, 2);
    expect_grant(0, 2, "R6 waiter served before new acquirer");
    fork
      send(3, 1'b1, 2);
      send(6, 1'b0, 2);
    join
    expect_grant(6, 2, "R6 acquirer queued behind waiter");
    send(0, 1'b1, 2);
    send(6, 1'b1, 2);
    @(negedge clk);

    // R9 round robin after reset
    do_reset();
    expect_grant(1, 3, "R9 first acquire");
    expect_grant(2, 0, "R9 second acquire");
    fork
      send(1, 1'b0, 3);
      send(2, 1'b0, 0);
      begin
        #1;
        chk(req_ready_o[1] && !req_ready_o[2], "R9 one acquire per cycle",
            int'(req_ready_o[2:1]), 1);
      end
    join
    @(negedge clk);

    // R7 self deadlock
    do_reset();
    expect_grant(3, 0, "R1 grant before self wait");
    send(3, 1'b0, 0);
    send(3, 1'b0, 0);
    @(negedge clk);
    chk(deadlock_o && deadlock_core_o == 3'd3, "R7 self deadlock", int'(deadlock_core_o), 3);

    // R7 two-core cycle
    do_reset();
    expect_grant(0, 0, "R1 core0 lock0");
    send(0, 1'b0, 0);
    expect_grant(1, 1, "R1 core1 lock1");
    send(1, 1'b0, 1);
    send(0, 1'b0, 1);
    @(negedge clk);
    chk(!deadlock_o, "R7 open chain no deadlock", int'(deadlock_o), 0);
    send(1, 1'b0, 0);
    @(negedge clk);
    chk(deadlock_o && deadlock_core_o <= 3'd1, "R7 two-core deadlock",
        int'(deadlock_core_o), 0);

    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R3 all expected grants seen", exp_q.size(), 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule